// File: doc/BRIEF.md
# Four-Plane Graphics Write Datapath

This block forms the write half of a four-plane graphics memory controller. Each CPU write gives one byte and the contents of four 8-bit plane latches. The latches hold whatever the most recent read of the target address loaded. The block turns these into four plane data bytes and four plane write enables. Software must read the target address before a read-modify-write, because pixels the write leaves alone are refilled from the latches.

Three write modes are supported:

- **Broadcast mode:** the CPU byte is rotated, combined with each latch by a selectable logic function, and then merged with the latch pixel by pixel through a bit mask.
- **Latch-copy mode:** the four latches are stored back unchanged.
- **Nibble-expand mode:** each of the low four CPU bits is spread into a full byte for its own plane.

A per-plane map mask decides which planes receive the write. Software programs the control registers through two index/data register pairs: one for the graphics group and one for the sequencer group.

The result and the target address are registered. They appear one cycle after the CPU write, together with a single-cycle write strobe for each enabled plane.

Top module: `planar_write_path`

## Requirements
- R1: After reset the write mode is 0, the rotate count is 0, the logic function is pass, the bit mask is 0xFF and the map mask is 0xF. All output strobes and output data are 0.
- R2: Configuration select value 0 loads the graphics index and select value 1 writes the graphics register that the index points to. Graphics index 0 is the rotate register, with the count in bits 2:0 and the function in bits 4:3. Graphics index 5 is the mode register, with the mode in bits 1:0. Graphics index 8 is the bit mask. Select value 2 loads the sequencer index and select value 3 writes the register it points to; sequencer index 2 is the map mask, in bits 3:0. A data write to any other index changes nothing, and an index stays in place across data writes.
- R3: In mode 0 the CPU byte is rotated right by the rotate count before any other step.
- R4: In modes 0 and 2 the logic function combines the source byte with each plane's latch. Function code 0 passes the source, 1 is AND, 2 is OR and 3 is XOR.
- R5: In modes 0 and 2 an output bit comes from the logic result where the bit mask bit is 1, and from the latch where it is 0.
- R6: In modes 0 and 2, plane p is strobed only if map mask bit p is 1.
- R7: In mode 1 each plane receives its latch byte unchanged and all four planes are strobed. Rotate, logic function, bit mask and map mask have no effect.
- R8: In mode 2 the source byte for plane p is CPU bit p repeated eight times. No rotation is applied.
- R9: Mode value 3 is reserved; a CPU write in this mode strobes no plane.
- R10: Results, strobes and the address appear on the cycle after a CPU write, and the strobes last one cycle. Without a CPU write, no strobe is raised.
- R11: A configuration write in the same cycle as a CPU write takes effect only from the next CPU write on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | 0 graphics index, 1 graphics data, 2 sequencer index, 3 sequencer data |
| cfgData | input | 8 | Configuration write byte |
| cpuWe | input | 1 | CPU write request |
| cpuData | input | 8 | CPU write byte |
| cpuAddr | input | ADDR_W | Target byte address |
| latchIn | input | 32 | Plane latches, plane p in bits 8p+7:8p |
| planeData | output | 32 | Write data, plane p in bits 8p+7:8p |
| planeWe | output | 4 | Per-plane write strobe |
| planeAddr | output | ADDR_W | Registered target address |

## Verification
A configuration register write and a CPU write can arrive in the same cycle. The CPU write must then use the settings from before the update. The bench provokes this both in a directed case, where the mode and bit mask are changed alongside a write, and in random traffic, where configuration and CPU strobes are raised independently. The bench reference model updates its registers only after computing the expected result of that cycle, so any early or late adoption of a setting shows up as a data or strobe mismatch on the following cycle.

// File: rtl/wpw_pkg.sv
package wpw_pkg;
  localparam int NUM_PLANES = 4;
  localparam int PIX_W      = 8;
  localparam int ROT_W      = $clog2(PIX_W);
  localparam int BUS_W      = NUM_PLANES * PIX_W;

  typedef enum logic [1:0] {
    WM_BROADCAST = 2'd0,
    WM_LATCH_COPY = 2'd1,
    WM_NIBBLE_EXPAND = 2'd2,
    WM_RESERVED = 2'd3
  } writeMode_e;

  typedef enum logic [1:0] {
    LOP_PASS = 2'd0,
    LOP_AND  = 2'd1,
    LOP_OR   = 2'd2,
    LOP_XOR  = 2'd3
  } logicOp_e;

  typedef struct packed {
    logic                  cpuStrobe;
    writeMode_e            mode;
    logic [ROT_W-1:0]      rotCount;
    logicOp_e              op;
    logic [PIX_W-1:0]      bitMask;
    logic [NUM_PLANES-1:0] mapMask;
  } ctrlStrobes_t;
endpackage

// File: rtl/wpw_ctrl.sv
module wpw_ctrl
  import wpw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgWe,
  input  logic [1:0]   cfgSel,
  input  logic [7:0]   cfgData,
  input  logic         cpuWe,
  output ctrlStrobes_t ctrl
);
  localparam logic [1:0] SEL_GFX_IDX = 2'd0;
  localparam logic [1:0] SEL_GFX_DAT = 2'd1;
  localparam logic [1:0] SEL_SEQ_IDX = 2'd2;
  localparam logic [1:0] SEL_SEQ_DAT = 2'd3;

  localparam logic [7:0] GIDX_ROTATE  = 8'd0;
  localparam logic [7:0] GIDX_MODE    = 8'd5;
  localparam logic [7:0] GIDX_BITMASK = 8'd8;
  localparam logic [7:0] SIDX_MAPMASK = 8'd2;

  logic [7:0]            gfxIdx, seqIdx;
  writeMode_e            modeReg;
  logic [ROT_W-1:0]      rotReg;
  logicOp_e              opReg;
  logic [PIX_W-1:0]      bitMaskReg;
  logic [NUM_PLANES-1:0] mapMaskReg;

  logic gfxDataWr, seqDataWr;
  assign gfxDataWr = cfgWe && (cfgSel == SEL_GFX_DAT);
  assign seqDataWr = cfgWe && (cfgSel == SEL_SEQ_DAT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gfxIdx <= '0;
      seqIdx <= '0;
    end else if (cfgWe) begin
      if (cfgSel == SEL_GFX_IDX) gfxIdx <= cfgData;
      if (cfgSel == SEL_SEQ_IDX) seqIdx <= cfgData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg    <= WM_BROADCAST;
      rotReg     <= '0;
      opReg      <= LOP_PASS;
      bitMaskReg <= '1;
    end else if (gfxDataWr) begin
      case (gfxIdx)
        GIDX_ROTATE: begin
          rotReg <= cfgData[ROT_W-1:0];
          opReg  <= logicOp_e'(cfgData[ROT_W+1:ROT_W]);
        end
        GIDX_MODE:    modeReg    <= writeMode_e'(cfgData[1:0]);
        GIDX_BITMASK: bitMaskReg <= cfgData[PIX_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mapMaskReg <= '1;
    end else if (seqDataWr && (seqIdx == SIDX_MAPMASK)) begin
      mapMaskReg <= cfgData[NUM_PLANES-1:0];
    end
  end

  always_comb begin
    ctrl.cpuStrobe = cpuWe;
    ctrl.mode      = modeReg;
    ctrl.rotCount  = rotReg;
    ctrl.op        = opReg;
    ctrl.bitMask   = bitMaskReg;
    ctrl.mapMask   = mapMaskReg;
  end
endmodule

// File: rtl/wpw_datapath.sv
module wpw_datapath
  import wpw_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          ctrl,
  input  logic [7:0]            cpuData,
  input  logic [ADDR_W-1:0]     cpuAddr,
  input  logic [BUS_W-1:0]      latchIn,
  output logic [BUS_W-1:0]      planeData,
  output logic [NUM_PLANES-1:0] planeWe,
  output logic [ADDR_W-1:0]     planeAddr
);
  logic [PIX_W-1:0]      rotated;
  logic [2*PIX_W-1:0]    doubled;
  logic [BUS_W-1:0]      nextData;
  logic [NUM_PLANES-1:0] nextWe;

  assign doubled = {cpuData[PIX_W-1:0], cpuData[PIX_W-1:0]} >> ctrl.rotCount;
  assign rotated = doubled[PIX_W-1:0];

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    logic [PIX_W-1:0] latchByte, srcByte, aluByte, mergedByte;

    assign latchByte = latchIn[p*PIX_W +: PIX_W];

    always_comb begin
      if (ctrl.mode == WM_NIBBLE_EXPAND) srcByte = {PIX_W{cpuData[p]}};
      else                               srcByte = rotated;
    end

    always_comb begin
      case (ctrl.op)
        LOP_AND: aluByte = srcByte & latchByte;
        LOP_OR:  aluByte = srcByte | latchByte;
        LOP_XOR: aluByte = srcByte ^ latchByte;
        default: aluByte = srcByte;
      endcase
    end

    assign mergedByte = (aluByte & ctrl.bitMask) | (latchByte & ~ctrl.bitMask);

    always_comb begin
      case (ctrl.mode)
        WM_LATCH_COPY: begin
          nextData[p*PIX_W +: PIX_W] = latchByte;
          nextWe[p]                  = 1'b1;
        end
        WM_RESERVED: begin
          nextData[p*PIX_W +: PIX_W] = mergedByte;
          nextWe[p]                  = 1'b0;
        end
        default: begin
          nextData[p*PIX_W +: PIX_W] = mergedByte;
          nextWe[p]                  = ctrl.mapMask[p];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      planeData <= '0;
      planeWe   <= '0;
      planeAddr <= '0;
    end else begin
      planeWe <= ctrl.cpuStrobe ? nextWe : '0;
      if (ctrl.cpuStrobe) begin
        planeData <= nextData;
        planeAddr <= cpuAddr;
      end
    end
  end
endmodule

// File: rtl/planar_write_path.sv
module planar_write_path
  import wpw_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic [1:0]            cfgSel,
  input  logic [7:0]            cfgData,
  input  logic                  cpuWe,
  input  logic [7:0]            cpuData,
  input  logic [ADDR_W-1:0]     cpuAddr,
  input  logic [BUS_W-1:0]      latchIn,
  output logic [BUS_W-1:0]      planeData,
  output logic [NUM_PLANES-1:0] planeWe,
  output logic [ADDR_W-1:0]     planeAddr
);
  ctrlStrobes_t ctrlBus;

  wpw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgData(cfgData), .cpuWe(cpuWe), .ctrl(ctrlBus)
  );

  wpw_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrlBus), .cpuData(cpuData),
    .cpuAddr(cpuAddr), .latchIn(latchIn), .planeData(planeData),
    .planeWe(planeWe), .planeAddr(planeAddr)
  );
endmodule

// File: rtl/wpw_checker.sv
module wpw_checker
  import wpw_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  cpuWe,
  input logic [BUS_W-1:0]      latchIn,
  input logic [BUS_W-1:0]      planeData,
  input logic [NUM_PLANES-1:0] planeWe,
  input logic [1:0]            mode,
  input logic [PIX_W-1:0]      bitMask,
  input logic [NUM_PLANES-1:0] mapMask
);
  a_r10_no_strobe_idle: assert property (@(posedge clk) disable iff (!rstN)
    !cpuWe |=> planeWe == '0);

  a_r7_latch_copy: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWe && mode == 2'd1) |=> (planeWe == '1 && planeData == $past(latchIn)));

  a_r6_map_mask: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWe && (mode == 2'd0 || mode == 2'd2)) |=> planeWe == $past(mapMask));

  a_r5_bit_mask_keeps_latch: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWe && (mode == 2'd0 || mode == 2'd2)) |=>
      ((planeData & ~{NUM_PLANES{$past(bitMask)}}) ==
       ($past(latchIn) & ~{NUM_PLANES{$past(bitMask)}})));

  a_r9_reserved_mode: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWe && mode == 2'd3) |=> planeWe == '0);
endmodule

bind planar_write_path wpw_checker u_wpw_checker (
  .clk(clk), .rstN(rstN), .cpuWe(cpuWe), .latchIn(latchIn),
  .planeData(planeData), .planeWe(planeWe), .mode(ctrlBus.mode),
  .bitMask(ctrlBus.bitMask), .mapMask(ctrlBus.mapMask)
);

// File: tb/test_planar_write_path.sv
module test_planar_write_path;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int WATCHDOG = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [7:0]  cfgData = '0;
  logic        cpuWe = 1'b0;
  logic [7:0]  cpuData = '0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [31:0] latchIn = '0;
  logic [31:0] planeData;
  logic [3:0]  planeWe;
  logic [ADDR_W-1:0] planeAddr;

  int compared = 0;
  int mismatched = 0;

  // reference model registers
  logic [1:0] mMode = 0;
  logic [2:0] mRot = 0;
  logic [1:0] mOp = 0;
  logic [7:0] mBm = 8'hFF;
  logic [3:0] mMm = 4'hF;
  logic [7:0] mGIdx = 0, mSIdx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  planar_write_path #(.ADDR_W(ADDR_W)) i_planar_write_path (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .cpuWe(cpuWe), .cpuData(cpuData), .cpuAddr(cpuAddr), .latchIn(latchIn),
    .planeData(planeData), .planeWe(planeWe), .planeAddr(planeAddr)
  );

  function automatic logic [7:0] rotr(input logic [7:0] v, input logic [2:0] n);
    logic [7:0] r = v;
    for (int i = 0; i < int'(n); i++) r = {r[0], r[7:1]};
    return r;
  endfunction

  function automatic logic [7:0] applyOp(input logic [7:0] s, input logic [7:0] l);
    case (mOp)
      2'd1: return s & l;
      2'd2: return s | l;
      2'd3: return s ^ l;
      default: return s;
    endcase
  endfunction

  function automatic logic [35:0] refWrite(input logic [7:0] cpu, input logic [31:0] lat);
    logic [31:0] d = '0;
    logic [3:0] we = '0;
    for (int p = 0; p < 4; p++) begin
      logic [7:0] l = lat[p*8 +: 8];
      logic [7:0] s = (mMode == 2'd2) ? (cpu[p] ? 8'hFF : 8'h00) : rotr(cpu, mRot);
      logic [7:0] a = applyOp(s, l);
      if (mMode == 2'd1) begin
        d[p*8 +: 8] = l;
        we[p] = 1'b1;
      end else begin
        d[p*8 +: 8] = (a & mBm) | (l & ~mBm);
        we[p] = (mMode == 2'd3) ? 1'b0 : mMm[p];
      end
    end
    return {we, d};
  endfunction

  task automatic modelCfg(input logic we, input logic [1:0] sel, input logic [7:0] dat);
    if (!we) return;
    case (sel)
      2'd0: mGIdx = dat;
      2'd2: mSIdx = dat;
      2'd1: begin
        if (mGIdx == 8'd0) begin mRot = dat[2:0]; mOp = dat[4:3]; end
        else if (mGIdx == 8'd5) mMode = dat[1:0];
        else if (mGIdx == 8'd8) mBm = dat;
      end
      default: if (mSIdx == 8'd2) mMm = dat[3:0];
    endcase
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check after the following posedge
  task automatic cycle(input logic cw, input logic [1:0] cs, input logic [7:0] cd,
                       input logic pw, input logic [7:0] pd,
                       input logic [ADDR_W-1:0] pa, input logic [31:0] lat, input string tag);
    logic [35:0] exp;
    cfgWe = cw; cfgSel = cs; cfgData = cd;
    cpuWe = pw; cpuData = pd; cpuAddr = pa; latchIn = lat;
    exp = refWrite(pd, lat);
    modelCfg(cw, cs, cd);
    @(posedge clk);
    #1;
    if (!pw) begin
      check({tag, " R10 idle"}, 64'(planeWe), 64'(0));
    end else begin
      check({tag, " strobes"}, 64'(planeWe), 64'(exp[35:32]));
      if (exp[35:32] != 0) begin
        check({tag, " data"}, 64'(planeData), 64'(exp[31:0]));
        check({tag, " R10 addr"}, 64'(planeAddr), 64'(pa));
      end
    end
    @(negedge clk);
  endtask

  task automatic cfgWrite(input logic [1:0] idxSel, input logic [7:0] idx, input logic [7:0] dat);
    cycle(1'b1, idxSel, idx, 1'b0, 8'h0, '0, '0, "cfg");
    cycle(1'b1, idxSel + 2'd1, dat, 1'b0, 8'h0, '0, '0, "cfg");
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1 reset strobes", 64'(planeWe), 64'(0));
    check("R1 reset data", 64'(planeData), 64'(0));

    // R1 defaults: mode 0, no rotate, pass, full masks
    cycle(0, 0, 0, 1, 8'hA5, 16'h0100, 32'h1234_5678, "R1 default mode0");
    // R3 rotate by 3 with pass
    cfgWrite(2'd0, 8'd0, 8'h03);
    cycle(0, 0, 0, 1, 8'h81, 16'h0101, 32'hFFFF_0000, "R3 rotate3");
    // R4 each logic op
    for (int op = 1; op < 4; op++) begin
      cfgWrite(2'd0, 8'd0, 8'(op << 3));
      cycle(0, 0, 0, 1, 8'hF0, 16'h0200, 32'hCC33_AA55, "R4 logic op");
    end
    // R5 bit mask and R6 map mask
    cfgWrite(2'd0, 8'd8, 8'h0F);
    cfgWrite(2'd2, 8'd2, 8'h05);
    cycle(0, 0, 0, 1, 8'h3C, 16'h0300, 32'h0F0F_F0F0, "R5 R6 masked");
    // R2 ignored index: graphics 7 and sequencer 4
    cfgWrite(2'd0, 8'd7, 8'h00);
    cfgWrite(2'd2, 8'd4, 8'h00);
    cycle(0, 0, 0, 1, 8'h3C, 16'h0301, 32'h0F0F_F0F0, "R2 unknown index");
    // R8 mode 2
    cfgWrite(2'd0, 8'd5, 8'h02);
    cycle(0, 0, 0, 1, 8'h0A, 16'h0400, 32'h1122_3344, "R8 nibble");
    // R7 mode 1 ignores masks
    cfgWrite(2'd0, 8'd5, 8'h01);
    cycle(0, 0, 0, 1, 8'hFF, 16'h0500, 32'hDEAD_BEEF, "R7 latch copy");
    // R9 reserved mode
    cfgWrite(2'd0, 8'd5, 8'h03);
    cycle(0, 0, 0, 1, 8'hFF, 16'h0600, 32'hDEAD_BEEF, "R9 reserved");
    // R11: mode change alongside a write uses old mode (graphics index still 5)
    cycle(1, 2'd1, 8'h00, 1, 8'h55, 16'h0700, 32'h0102_0304, "R11 same cycle old");
    cycle(0, 0, 0, 1, 8'h55, 16'h0701, 32'h0102_0304, "R11 next uses new");
    // R10 back-to-back then idle
    cycle(0, 0, 0, 1, 8'h99, 16'h0800, 32'h0, "R10 b2b");
    cycle(0, 0, 0, 0, 8'h99, 16'h0801, 32'h0, "R10 gap");

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] pick = 8'($urandom_range(0, 5));
      logic [1:0] sel = 2'($urandom_range(0, 3));
      logic [7:0] dat = 8'($urandom);
      string tag;
      if (sel[0] == 1'b0) dat = (sel == 2'd0) ? ((pick < 3) ? 8'(pick == 0 ? 0 : (pick == 1 ? 5 : 8)) : dat)
                                              : ((pick < 4) ? 8'd2 : dat);
      case (mMode)
        2'd0: tag = "R3 R4 R5 R6 R11 rand";
        2'd1: tag = "R7 R11 rand";
        2'd2: tag = "R8 R4 R5 R6 R11 rand";
        default: tag = "R9 R11 rand";
      endcase
      cycle(1'($urandom_range(0, 1)), sel, dat, ($urandom_range(0, 3) != 0),
            8'($urandom), ADDR_W'($urandom), $urandom, tag);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule